// File: doc/BRIEF.md
# Clear-on-read interrupt aggregator

This block gathers single-cycle event pulses from six internal source groups into six 8-bit status registers. A set bit stays set until software reads its register. Reading returns the latched bits and clears them in the same access. A global summary register holds one bit per group. That bit is set when the group has any set status bit that its per-bit mask does not block.

The block drives one interrupt request pad. The request is active while any unmasked status bit is set. Software reads the summary to find the active group, then reads that group's status register. The read clears the bits and, if nothing else is pending, releases the request. A 2-bit configuration field sets two things: whether the pad is driven as open-drain or push-pull, and whether the request is active high or active low.

The register bus has a 4-bit address, separate read and write strobes, and registered read data. Read data appears in the cycle after the read strobe.

Top module: `intagg_top`

## Requirements
- R1: A 1 on event input bit `8*g+b` sets bit b of status register g at the next clock edge. The bit stays set, whatever its mask, until that register is read.
- R2: A read of status register g (address 1+g) returns its latched bits and clears them. If no other unmasked bit is pending, the request becomes inactive in the cycle after the read.
- R3: An event that arrives in the same cycle as the read of its register is not lost. It is absent from the returned data and set in the register after the read.
- R4: Bit g of the global register (address 0) is 1 exactly when status g has a set bit whose mask bit is 0. Reading the global register clears nothing.
- R5: After reset, all status bits are 0, every mask register is 0xFF and the configuration is 0. The request is therefore inactive.
- R6: The request is active when, and only when, any status bit with a mask bit of 0 is set. Masked bits still latch and can be read.
- R7: Configuration bit 0 selects the pad mode: 1 is open-drain and 0 is push-pull. Bit 1 selects the active level: 1 is active high and 0 is active low. In push-pull mode the output enable is always 1. The output is the active level while the request is active and its inverse otherwise.
- R8: In open-drain mode the output enable is 1 only while the request is active, and the output value is always the active level.
- R9: Writes to the global register and to the status registers have no effect. Reads of unmapped addresses (7 and 14) return 0.
- R10: The address map is:
  - address 0: global register
  - addresses 1 to 6: status registers
  - addresses 8 to 13: mask registers, read/write
  - address 15: configuration, in bits 1:0; upper bits read as 0

  Read data is registered: it is valid in the cycle after the read strobe and held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 48 | Event pulses; bit 8*g+b feeds bit b of group g |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe (takes priority over read) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_out | output | 1 | Interrupt pad output value |
| int_oe | output | 1 | Interrupt pad output enable |

## Verification
The bench sweeps each of the 48 event bits in turn and checks the request, the summary bit and the status value on every one. A bit-index or group-index slip would therefore show up as a wrong summary or status value. It re-reads the summary register straight after reading it. A design that wrongly cleared status on a summary read would drop the request at that point. It also fires an event in the same cycle as the read that clears its register. A design that let the clear win would lose that event, and the next read would return 0. Finally, it walks all four configuration codes, both with the request idle and with it active. A swapped mode or polarity bit shows up as a wrong output value or output enable.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int ADDR_W    = 4;
  localparam int GLOB_ADDR = 0;
  localparam int STAT_BASE = 1;
  localparam int MASK_BASE = 8;
  localparam int CFG_ADDR  = 15;

  // bit 1: active level, bit 0: open-drain select
  typedef struct packed {
    logic act_high;
    logic open_drain;
  } int_cfg_t;
endpackage

// File: rtl/intagg_grp.sv
module intagg_grp #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] evt_i,
  input  logic             rd_clr_i,
  input  logic             mask_we_i,
  input  logic [GRP_W-1:0] mask_wdata_i,
  output logic [GRP_W-1:0] status_o,
  output logic [GRP_W-1:0] mask_o,
  output logic             summary_o
);
  logic [GRP_W-1:0] status_q, status_d;
  logic [GRP_W-1:0] mask_q, mask_d;

  always_comb begin
    status_d = (status_q & ~{GRP_W{rd_clr_i}}) | evt_i;
    mask_d   = mask_q;
    if (mask_we_i) mask_d = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o  = status_q;
  assign mask_o    = mask_q;
  assign summary_o = |(status_q & ~mask_q);

  // R1
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  // R3
  clr_keeps_new_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (status_q == $past(evt_i)));
  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/intagg_regif.sv
module intagg_regif
  import intagg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int GRP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [GRP_W-1:0]         bus_wdata,
  input  logic [NUM_GRP*GRP_W-1:0] status_flat,
  input  logic [NUM_GRP*GRP_W-1:0] mask_flat,
  input  logic [NUM_GRP-1:0]       glob,
  output logic [NUM_GRP-1:0]       stat_rd,
  output logic [NUM_GRP-1:0]       mask_we,
  output int_cfg_t                 cfg_o,
  output logic [GRP_W-1:0]         rdata_o
);
  logic             rd_en;
  logic [GRP_W-1:0] rdata_q, rdata_d, rsel;
  int_cfg_t         cfg_q, cfg_d;

  assign rd_en = bus_rd && !bus_wr;

  always_comb begin
    stat_rd = '0;
    mask_we = '0;
    rsel    = '0;
    if (bus_addr == ADDR_W'(GLOB_ADDR)) rsel = GRP_W'(glob);
    if (bus_addr == ADDR_W'(CFG_ADDR))  rsel = GRP_W'(cfg_q);
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_addr == ADDR_W'(STAT_BASE + g)) begin
        stat_rd[g] = rd_en;
        rsel       = status_flat[g*GRP_W +: GRP_W];
      end
      if (bus_addr == ADDR_W'(MASK_BASE + g)) begin
        mask_we[g] = bus_wr;
        rsel       = mask_flat[g*GRP_W +: GRP_W];
      end
    end
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rsel;
    cfg_d = cfg_q;
    if (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) cfg_d = int_cfg_t'(bus_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      cfg_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
  // R2
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_rd));
endmodule

// File: rtl/intagg_pad.sv
module intagg_pad
  import intagg_pkg::*;
(
  input  logic     req_i,
  input  int_cfg_t cfg_i,
  output logic     int_out_o,
  output logic     int_oe_o
);
  always_comb begin
    if (cfg_i.open_drain) begin
      int_oe_o  = req_i;
      int_out_o = cfg_i.act_high;
    end else begin
      int_oe_o  = 1'b1;
      int_out_o = req_i ? cfg_i.act_high : ~cfg_i.act_high;
    end
  end
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int GRP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GRP*GRP_W-1:0] evt_i,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [GRP_W-1:0]         bus_wdata,
  output logic [GRP_W-1:0]         bus_rdata,
  output logic                     int_out,
  output logic                     int_oe
);
  localparam int FLAT_W = NUM_GRP * GRP_W;

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [FLAT_W-1:0]  status_flat, mask_flat;
  logic [NUM_GRP-1:0] glob, stat_rd, mask_we;
  logic               req;
  int_cfg_t           cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    intagg_grp #(.GRP_W(GRP_W)) u_grp (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .evt_i        (evt_i[g*GRP_W +: GRP_W]),
      .rd_clr_i     (stat_rd[g]),
      .mask_we_i    (mask_we[g]),
      .mask_wdata_i (bus_wdata),
      .status_o     (status_flat[g*GRP_W +: GRP_W]),
      .mask_o       (mask_flat[g*GRP_W +: GRP_W]),
      .summary_o    (glob[g])
    );
  end

  intagg_regif #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_regif (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .status_flat (status_flat),
    .mask_flat   (mask_flat),
    .glob        (glob),
    .stat_rd     (stat_rd),
    .mask_we     (mask_we),
    .cfg_o       (cfg),
    .rdata_o     (bus_rdata)
  );

  assign req = |glob;

  intagg_pad u_pad (
    .req_i     (req),
    .cfg_i     (cfg),
    .int_out_o (int_out),
    .int_oe_o  (int_oe)
  );

  // R4
  glob_read_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(GLOB_ADDR))
      |=> ((status_flat & $past(status_flat)) == $past(status_flat)));
  // R5
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> ((&mask_flat) && (status_flat == '0)));
  // R6
  req_matches_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req == ((status_flat & ~mask_flat) != '0));
  // R7
  pushpull_oe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg.open_drain |-> int_oe);
  // R8
  opendrain_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.open_drain && int_oe) |-> (int_out == cfg.act_high));
endmodule

// File: tb/tb_intagg_top.sv
`timescale 1ns/1ps
module tb_intagg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] evt;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        int_out, int_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  intagg_top dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
    .int_out(int_out), .int_oe(int_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse(input int g, input logic [7:0] v);
    @(negedge clk); evt[g*8 +: 8] = v;
    @(negedge clk); evt = '0;
  endtask

  // expected pad pins for a configuration code and request state
  task automatic chk_pad(input string req, input logic [1:0] c, input logic act);
    logic exp_oe, exp_out;
    exp_oe  = c[0] ? act : 1'b1;
    exp_out = c[0] ? c[1] : (act ? c[1] : ~c[1]);
    chk(req, {6'b0, int_oe, int_out}, {6'b0, exp_oe, exp_out});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset state, push-pull active-low, inactive
    chk_pad("R5 pad idle", 2'b00, 1'b0);
    for (int g = 0; g < 6; g++) begin
      rd_reg(4'(8 + g), rv); chk("R5 mask reset", rv, 8'hFF);
      rd_reg(4'(1 + g), rv); chk("R5 status reset", rv, 8'h00);
    end
    rd_reg(4'd0, rv);  chk("R5 global reset", rv, 8'h00);
    rd_reg(4'd15, rv); chk("R5 cfg reset", rv, 8'h00);

    // R6: masked events latch but raise nothing
    pulse(0, 8'hFF);
    chk_pad("R6 masked no req", 2'b00, 1'b0);
    rd_reg(4'd0, rv); chk("R4 masked global", rv, 8'h00);
    rd_reg(4'd1, rv); chk("R6 masked latched", rv, 8'hFF);
    rd_reg(4'd1, rv); chk("R2 cleared", rv, 8'h00);

    // R10: unmask everything, read back
    for (int g = 0; g < 6; g++) begin
      wr_reg(4'(8 + g), 8'h00);
      rd_reg(4'(8 + g), rv); chk("R10 mask rw", rv, 8'h00);
    end

    // R1 R2 R4 R6: sweep every event bit
    for (int g = 0; g < 6; g++) begin
      for (int b = 0; b < 8; b++) begin
        pulse(g, 8'(1 << b));
        chk_pad("R6 req active", 2'b00, 1'b1);
        rd_reg(4'd0, rv); chk("R4 global bit", rv, 8'(1 << g));
        rd_reg(4'd0, rv); chk("R4 global read no clear", rv, 8'(1 << g));
        rd_reg(4'(1 + g), rv); chk("R1 status bit", rv, 8'(1 << b));
        chk_pad("R2 req released", 2'b00, 1'b0);
        rd_reg(4'(1 + g), rv); chk("R2 status cleared", rv, 8'h00);
      end
    end

    // R6: partial mask
    wr_reg(4'd10, 8'hF0);
    pulse(2, 8'h20);
    chk_pad("R6 partial masked", 2'b00, 1'b0);
    rd_reg(4'd0, rv); chk("R4 partial global", rv, 8'h00);
    pulse(2, 8'h02);
    chk_pad("R6 partial unmasked", 2'b00, 1'b1);
    rd_reg(4'd3, rv); chk("R6 both latched", rv, 8'h22);
    chk_pad("R2 partial released", 2'b00, 1'b0);
    wr_reg(4'd10, 8'h00);

    // R3: event in the same cycle as the clearing read
    pulse(1, 8'h08);
    @(negedge clk); addr = 4'd2; rd = 1'b1; evt[8 +: 8] = 8'h40;
    @(negedge clk); rd = 1'b0; evt = '0; rv = rdata;
    chk("R3 read old bits", rv, 8'h08);
    chk_pad("R3 req kept", 2'b00, 1'b1);
    rd_reg(4'd2, rv); chk("R3 new event kept", rv, 8'h40);

    // R9: writes to read-only registers, unmapped reads
    pulse(4, 8'h11);
    wr_reg(4'd5, 8'h00);
    wr_reg(4'd0, 8'h00);
    rd_reg(4'd0, rv); chk("R9 global write ignored", rv, 8'h10);
    rd_reg(4'd5, rv); chk("R9 status write ignored", rv, 8'h11);
    wr_reg(4'd1, 8'hFF);
    rd_reg(4'd1, rv); chk("R9 status write no set", rv, 8'h00);
    rd_reg(4'd7, rv);  chk("R9 unmapped 7", rv, 8'h00);
    rd_reg(4'd14, rv); chk("R9 unmapped 14", rv, 8'h00);

    // R7 R8: configuration sweep
    for (int c = 0; c < 4; c++) begin
      wr_reg(4'd15, 8'(c));
      rd_reg(4'd15, rv); chk("R10 cfg rw", rv, 8'(c));
      chk_pad(c[0] ? "R8 idle" : "R7 idle", 2'(c), 1'b0);
      pulse(5, 8'h80);
      chk_pad(c[0] ? "R8 active" : "R7 active", 2'(c), 1'b1);
      rd_reg(4'd6, rv); chk("R2 cfg sweep clear", rv, 8'h80);
      chk_pad(c[0] ? "R8 released" : "R7 released", 2'(c), 1'b0);
    end
    wr_reg(4'd15, 8'hFF);
    rd_reg(4'd15, rv); chk("R10 cfg upper bits zero", rv, 8'h03);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule